// File: doc/BRIEF.md
# Receive frame status trailer generator

This block sits beside a receive MAC datapath and builds a four-byte status record for every received Ethernet frame. It counts the bytes of the frame, including the 4-byte FCS, as the datapath strobes them. At the end-of-frame pulse it captures that count, the frame's four error indications and the current values of two running statistics counters. The two counters track runt frames and receive collisions.

The record is handed out one byte at a time in a fixed order. In stream mode the block drives the bytes onto an output byte stream on the four cycles right after end of frame, so that they land directly behind the last data byte in the receive buffer. In register mode a CPU reads one status location four times, and each read strobe steps to the next byte. If a frame ends while the previous record is still unread, the old record is kept and an overrun pulse is raised. Each statistics counter also raises a one-cycle flag when it wraps.

Top module: `rx_status_trailer`

## Requirements
- R1: A record has exactly four bytes, handed out in this order: byte 0 = frame count bits [7:0], byte 1 = status byte, byte 2 = runt counter value, byte 3 = receive collision counter value.
- R2: The frame count is 12 bits wide. It counts every cycle with `byte_vld` high, including such a cycle coincident with `eof`, and it starts from zero after each `eof`. Count bits [11:8] appear in bits [3:0] of byte 1.
- R3: Byte 1 bit 7 = `err_ovf`, bit 6 = `err_col`, bit 5 = `err_fram`, bit 4 = `err_fcs`, each sampled in the `eof` cycle.
- R4: With `append_mode` high, `tr_vld` is high on the four consecutive cycles that follow the `eof` cycle, carrying bytes 0 to 3 on `tr_data`, and is low afterwards. `tr_data` is 0 whenever `tr_vld` is low.
- R5: With `append_mode` low, `stat_rdy` goes high the cycle after `eof`. `rd_data` shows the current byte, starting at byte 0, and each `rd_stb` cycle steps to the next byte. After the fourth strobe `stat_rdy` falls and `rd_data` is 0. A strobe while `stat_rdy` is low has no effect.
- R6: Bytes 2 and 3 hold the 8-bit counter values from before the `eof` cycle. Each `runt_evt` or `col_evt` cycle adds one to its counter. Both counters are zero after reset.
- R7: When a counter steps from 255 to 0, its wrap flag (`runt_wrap`, `col_wrap`) is high for exactly the following cycle.
- R8: An `eof` that arrives while a record is unread and is not being finished in that cycle pulses `overrun` for one cycle. The unread record is kept unchanged.
- R9: The frame count saturates at 4095 and does not wrap.
- R10: After reset, `stat_rdy`, `tr_vld`, `overrun` and both wrap flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One frame byte accepted this cycle |
| eof | input | 1 | End of frame pulse |
| err_ovf | input | 1 | Frame had a FIFO overflow |
| err_col | input | 1 | Frame saw a collision |
| err_fram | input | 1 | Frame had a framing error |
| err_fcs | input | 1 | Frame failed its FCS check |
| runt_evt | input | 1 | A runt frame was discarded |
| col_evt | input | 1 | A receive collision occurred |
| append_mode | input | 1 | 1: stream the record, 0: register reads |
| rd_stb | input | 1 | Register read of the status location |
| tr_vld | output | 1 | Trailer byte valid on the stream |
| tr_data | output | 8 | Trailer byte on the stream |
| rd_data | output | 8 | Status register read data |
| stat_rdy | output | 1 | An unread record is held |
| overrun | output | 1 | A record was lost because the previous one was unread |
| runt_wrap | output | 1 | Runt counter wrapped |
| col_wrap | output | 1 | Collision counter wrapped |

## Verification
A read pointer that slips shows up at once as a byte out of order, on the first trailer byte after the fault, or as `stat_rdy` falling one strobe early or late. A byte counter that misses a strobe, or that fails to restart after `eof`, shows up in bytes 0 and 1 of the next record. A statistics counter that is off by one is only visible at the next frame's bytes 2 and 3, or at a wrap flag that comes too early or too late. A hold flag in the wrong state shows as an overrun pulse that is missing or spurious, or as a newer record overwriting one that is still unread.

// File: rtl/rxst_pkg.sv
package rxst_pkg;
  localparam int TRL_BYTES = 4;
  localparam int PTR_W     = $clog2(TRL_BYTES);
  localparam int LEN_W     = 12;
  localparam int BYTE_W    = 8;
  localparam int HI_W      = LEN_W - BYTE_W;

  typedef struct packed {
    logic ovf;
    logic col;
    logic fram;
    logic fcs;
  } rx_err_t;
endpackage

// File: rtl/rxst_bytecount.sv
module rxst_bytecount #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             eof,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] MAXV = {LEN_W{1'b1}};

  logic [LEN_W-1:0] cnt_q, cnt_d, len_inc;
  logic             cnt_en;

  always_comb begin
    len_inc = cnt_q;
    if (byte_vld && cnt_q != MAXV) len_inc = cnt_q + 1'b1;
    cnt_d  = eof ? '0 : len_inc;
    cnt_en = byte_vld | eof;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign len_o = len_inc;

  // R9: a full count never wraps to a small value
  p_len_saturates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == MAXV && !$past(eof)) |-> cnt_q == MAXV);
endmodule

// File: rtl/rxst_statcnt.sv
module rxst_statcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap_q, wrap_d;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    wrap_d = inc && (cnt_q == {W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      if (inc) cnt_q <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  // R7: the wrap flag is only seen with the counter back at zero
  p_wrap_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> cnt_o == '0);
endmodule

// File: rtl/rxst_seq.sv
module rxst_seq
  import rxst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eof,
  input  logic [LEN_W-1:0]  len,
  input  rx_err_t           err,
  input  logic [BYTE_W-1:0] runt_cnt,
  input  logic [BYTE_W-1:0] col_cnt,
  input  logic              append_mode,
  input  logic              rd_stb,
  output logic              stat_rdy,
  output logic              tr_vld,
  output logic [BYTE_W-1:0] tr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              overrun
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(TRL_BYTES - 1);

  logic [BYTE_W-1:0] rec_q [TRL_BYTES];
  logic [BYTE_W-1:0] rec_d [TRL_BYTES];
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              held_q, held_d, ovr_q, ovr_d;
  logic              consume, last, latch;
  logic [BYTE_W-1:0] cur;

  always_comb begin
    consume = held_q && (append_mode || rd_stb);
    last    = consume && (ptr_q == LAST_PTR);
    latch   = eof && (!held_q || last);
    ovr_d   = eof && held_q && !last;

    held_d = held_q;
    ptr_d  = ptr_q;
    if (latch) begin
      held_d = 1'b1;
      ptr_d  = '0;
    end else if (last) begin
      held_d = 1'b0;
      ptr_d  = '0;
    end else if (consume) begin
      ptr_d = ptr_q + 1'b1;
    end

    rec_d[0] = len[BYTE_W-1:0];
    rec_d[1] = {err, len[LEN_W-1:BYTE_W]};
    rec_d[2] = runt_cnt;
    rec_d[3] = col_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      ptr_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      held_q <= held_d;
      ptr_q  <= ptr_d;
      ovr_q  <= ovr_d;
    end
  end

  for (genvar g = 0; g < TRL_BYTES; g++) begin : g_rec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rec_q[g] <= '0;
      else if (latch) rec_q[g] <= rec_d[g];
    end
  end

  assign cur      = rec_q[ptr_q];
  assign stat_rdy = held_q;
  assign tr_vld   = held_q && append_mode;
  assign tr_data  = tr_vld ? cur : '0;
  assign rd_data  = (held_q && !append_mode) ? cur : '0;
  assign overrun  = ovr_q;

  // R1: a fresh record always starts at byte 0
  p_start_byte0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_q) |-> ptr_q == '0);

  // R8: an overrun leaves the old record pending
  p_overrun_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> stat_rdy);

  // R4: the stream runs without gaps until byte 3 has gone
  p_stream_gapless_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tr_vld) && $past(append_mode) && append_mode && $past(ptr_q) != LAST_PTR)
      |-> tr_vld);

  // R5: with no strobe in register mode the byte position holds
  p_ptr_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(held_q) && !$past(append_mode) && !$past(rd_stb) && !$past(eof))
      |-> $stable(ptr_q));
endmodule

// File: rtl/rx_status_trailer.sv
module rx_status_trailer
  import rxst_pkg::*;
#(
  parameter int STAT_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              eof,
  input  logic              err_ovf,
  input  logic              err_col,
  input  logic              err_fram,
  input  logic              err_fcs,
  input  logic              runt_evt,
  input  logic              col_evt,
  input  logic              append_mode,
  input  logic              rd_stb,
  output logic              tr_vld,
  output logic [BYTE_W-1:0] tr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              stat_rdy,
  output logic              overrun,
  output logic              runt_wrap,
  output logic              col_wrap
);
  logic [LEN_W-1:0]  len;
  logic [STAT_W-1:0] runt_cnt, col_cnt;
  rx_err_t           err;

  assign err = '{ovf: err_ovf, col: err_col, fram: err_fram, fcs: err_fcs};

  rxst_bytecount #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .eof(eof), .len_o(len)
  );

  rxst_statcnt #(.W(STAT_W)) u_runt (
    .clk(clk), .rst_n(rst_n), .inc(runt_evt), .cnt_o(runt_cnt), .wrap_o(runt_wrap)
  );

  rxst_statcnt #(.W(STAT_W)) u_col (
    .clk(clk), .rst_n(rst_n), .inc(col_evt), .cnt_o(col_cnt), .wrap_o(col_wrap)
  );

  rxst_seq u_seq (
    .clk(clk), .rst_n(rst_n), .eof(eof), .len(len), .err(err),
    .runt_cnt(BYTE_W'(runt_cnt)), .col_cnt(BYTE_W'(col_cnt)),
    .append_mode(append_mode), .rd_stb(rd_stb),
    .stat_rdy(stat_rdy), .tr_vld(tr_vld), .tr_data(tr_data),
    .rd_data(rd_data), .overrun(overrun)
  );

  // R10: nothing is offered while no record is held
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rdy |-> (!tr_vld && rd_data == '0));
endmodule

// File: tb/rx_status_trailer_tb.sv
module rx_status_trailer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 0, eof = 0, err_ovf = 0, err_col = 0, err_fram = 0, err_fcs = 0;
  logic runt_evt = 0, col_evt = 0, append_mode = 0, rd_stb = 0;
  logic tr_vld, stat_rdy, overrun, runt_wrap, col_wrap;
  logic [7:0] tr_data, rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int runt_tot = 0;
  int col_tot = 0;

  always #10 clk = ~clk;

  rx_status_trailer u_dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .eof(eof),
    .err_ovf(err_ovf), .err_col(err_col), .err_fram(err_fram), .err_fcs(err_fcs),
    .runt_evt(runt_evt), .col_evt(col_evt), .append_mode(append_mode),
    .rd_stb(rd_stb), .tr_vld(tr_vld), .tr_data(tr_data), .rd_data(rd_data),
    .stat_rdy(stat_rdy), .overrun(overrun), .runt_wrap(runt_wrap), .col_wrap(col_wrap)
  );

  // {len[31:20], errs[19:16], append[15], pad[14:12], runt[11:8], col[7:4], pad[3:0]}
  localparam logic [31:0] VEC [6] = '{
    {12'd64,   4'h0, 1'b1, 3'd0, 4'd1, 4'd0, 4'd0},
    {12'd1518, 4'h8, 1'b0, 3'd0, 4'd0, 4'd2, 4'd0},
    {12'd300,  4'h4, 1'b1, 3'd0, 4'd3, 4'd1, 4'd0},
    {12'd1,    4'h2, 1'b0, 3'd0, 4'd0, 4'd0, 4'd0},
    {12'd2047, 4'h1, 1'b1, 3'd0, 4'd2, 4'd5, 4'd0},
    {12'd4095, 4'hF, 1'b0, 3'd0, 4'd1, 4'd1, 4'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_evts(input int nr, input int nc);
    for (int i = 0; i < nr || i < nc; i++) begin
      @(negedge clk);
      runt_evt = (i < nr);
      col_evt  = (i < nc);
      if (i < nr) runt_tot++;
      if (i < nc) col_tot++;
    end
    @(negedge clk);
    runt_evt = 0;
    col_evt = 0;
  endtask

  // returns at the negedge after the eof cycle
  task automatic send_frame(input int len, input logic [3:0] errs);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      byte_vld = 1;
      eof = (i == len - 1);
      {err_ovf, err_col, err_fram, err_fcs} = (i == len - 1) ? errs : 4'h0;
    end
    @(negedge clk);
    byte_vld = 0;
    eof = 0;
    {err_ovf, err_col, err_fram, err_fcs} = 4'h0;
  endtask

  task automatic take_trailer(input logic [7:0] e0, input logic [7:0] e1,
                              input logic [7:0] e2, input logic [7:0] e3);
    logic [7:0] exp [4];
    exp = '{e0, e1, e2, e3};
    if (append_mode) begin
      for (int b = 0; b < 4; b++) begin
        chk("R4 tr_vld", tr_vld, 1);
        chk(b == 1 ? "R3 status byte" : "R1 stream byte", tr_data, exp[b]);
        @(negedge clk);
      end
      chk("R4 tr_vld low after byte 3", tr_vld, 0);
      chk("R4 tr_data zero", tr_data, 0);
    end else begin
      chk("R5 stat_rdy", stat_rdy, 1);
      for (int b = 0; b < 4; b++) begin
        chk(b == 1 ? "R3 status byte" : "R1 read byte", rd_data, exp[b]);
        rd_stb = 1;
        @(negedge clk);
        rd_stb = 0;
      end
      chk("R5 stat_rdy low after four reads", stat_rdy, 0);
      chk("R5 rd_data zero", rd_data, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 stat_rdy", stat_rdy, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 stat_rdy", stat_rdy, 0);
    chk("R10 tr_vld", tr_vld, 0);
    chk("R10 overrun", overrun, 0);
    chk("R10 wraps", {runt_wrap, col_wrap}, 0);

    // R6: counters zero after reset, seen in first record
    append_mode = 0;
    send_frame(10, 4'h0);
    take_trailer(8'd10, 8'h00, 8'd0, 8'd0);

    // table walk: R1 R2 R3 R4 R5 R6 R9
    for (int v = 0; v < 6; v++) begin
      int len = int'(VEC[v][31:20]);
      logic [3:0] er = VEC[v][19:16];
      append_mode = VEC[v][15];
      pulse_evts(int'(VEC[v][11:8]), int'(VEC[v][7:4]));
      send_frame(len, er);
      take_trailer(len[7:0], {er, len[11:8]}, 8'(runt_tot), 8'(col_tot));
    end

    // R2: byte count restarts after each frame, R5: idle strobe ignored
    append_mode = 0;
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    chk("R5 idle strobe stat_rdy", stat_rdy, 0);
    chk("R5 idle strobe rd_data", rd_data, 0);
    send_frame(3, 4'h0);
    take_trailer(8'd3, 8'h00, 8'(runt_tot), 8'(col_tot));

    // R9: saturation at 4095
    send_frame(4100, 4'h0);
    take_trailer(8'hFF, 8'h0F, 8'(runt_tot), 8'(col_tot));

    // R8: overrun keeps the first record
    send_frame(20, 4'h1);
    chk("R8 no overrun on first", overrun, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      byte_vld = 1;
      eof = (i == 4);
    end
    @(negedge clk);
    byte_vld = 0;
    eof = 0;
    chk("R8 overrun pulse", overrun, 1);
    @(negedge clk);
    chk("R8 overrun one cycle", overrun, 0);
    take_trailer(8'd20, 8'h10, 8'(runt_tot), 8'(col_tot));

    // R7: runt counter wrap
    pulse_evts(255 - (runt_tot % 256), 0);
    chk("R7 no early runt wrap", runt_wrap, 0);
    @(negedge clk);
    runt_evt = 1;
    runt_tot++;
    @(negedge clk);
    runt_evt = 0;
    chk("R7 runt_wrap", runt_wrap, 1);
    @(negedge clk);
    chk("R7 runt_wrap one cycle", runt_wrap, 0);

    // R7: collision counter wrap
    pulse_evts(0, 255 - (col_tot % 256));
    chk("R7 no early col wrap", col_wrap, 0);
    @(negedge clk);
    col_evt = 1;
    col_tot++;
    @(negedge clk);
    col_evt = 0;
    chk("R7 col_wrap", col_wrap, 1);
    @(negedge clk);
    chk("R7 col_wrap one cycle", col_wrap, 0);

    // R6: both counters now read zero
    append_mode = 1;
    send_frame(70, 4'h0);
    take_trailer(8'd70, 8'h00, 8'd0, 8'd0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule